// File: doc/BRIEF.md
# Set/Clear GPIO Register Bank

This block is a bank of 32 general-purpose I/O lines behind a small 32-bit register window. Each line has three pieces of state: an output-enable bit, an output-data bit and a synchronized copy of the pad input. Software never writes a register directly. Every write address either sets or clears the bits that are 1 in the write data. One core can therefore raise or drop any subset of lines in a single atomic write, with no read-modify-write race against another core that owns other lines of the same bank.

Reads use the same window. The value returned at an address usually comes from a different register than the one a write to that address changes. The set-enable address reads back the enable register. The clear-enable address reads as zero. The set-data address reads back the output-data register. The clear-data address reads back the synchronized input levels. The upper half of the window is reserved. Read data is registered: it appears on `bus_rdata` one cycle after the read strobe and holds until the next read. The block drives the pad output and the pad enable straight from its registers, and it generates no interrupts.

Top module: `gpio_sc_bank`

## Requirements
- R1: After reset, every output enable and every output-data bit is 0, and `bus_rdata` is 0.
- R2: A write to word index 0 (byte offset 0x00) sets each output-enable bit whose write-data bit is 1 and leaves all other enable bits unchanged.
- R3: A write to word index 1 (byte offset 0x04) clears each output-enable bit whose write-data bit is 1 and leaves all other enable bits unchanged.
- R4: A write to word index 2 (byte offset 0x08) sets each output-data bit whose write-data bit is 1 and leaves all other data bits unchanged.
- R5: A write to word index 3 (byte offset 0x0C) clears each output-data bit whose write-data bit is 1 and leaves all other data bits unchanged.
- R6: A read at word index 0 returns the enable register, and a read at word index 2 returns the output-data register. The value appears on `bus_rdata` one cycle after the read strobe, so a read issued the cycle after a write returns the updated value.
- R7: Reads at word index 1 and at word indices 4 to 7 (byte offsets 0x10 to 0x1C) return zero.
- R8: Writes to word indices 4 to 7 change neither register, and the registers hold their values in any cycle without a write.
- R9: Each pad input goes through a two-flop synchronizer. A level applied before a clock edge shows on `in_sync` after the second edge, and a read at word index 3 returns `in_sync`.
- R10: When a read and a write are strobed in the same cycle, the read returns the register value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe, one write per cycle |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | 3 | Word index, that is, byte-offset bits 4:2 |
| bus_wdata | input | 32 | Set or clear mask for the write |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Raw asynchronous pad input levels |
| pad_out | output | 32 | Output-data register to the pads |
| pad_oe | output | 32 | Output-enable register to the pads |
| in_sync | output | 32 | Pad inputs after the synchronizer |

## Verification
A wrong enable or data bit shows on `pad_oe` or `pad_out` on the edge right after the bad write, before any read is made. Each set and clear test therefore compares the pads with the expected mask result one cycle after the write, and then reads the register back. A decode fault that sends a write to the wrong register, or lets a reserved write through, shows as a bit that changes on the pads when it should not. A read-mux fault shows on `bus_rdata` one cycle after the read strobe. A synchronizer of the wrong depth shows as `in_sync` changing one edge too early or too late.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;

    localparam int DATA_W      = 32;
    localparam int NUM_LINES   = 32;
    localparam int WORD_IDX_W  = 3;
    localparam int SYNC_STAGES = 2;

    localparam logic [WORD_IDX_W-1:0] IDX_OE_SET = 3'd0;
    localparam logic [WORD_IDX_W-1:0] IDX_OE_CLR = 3'd1;
    localparam logic [WORD_IDX_W-1:0] IDX_DO_SET = 3'd2;
    localparam logic [WORD_IDX_W-1:0] IDX_DO_CLR = 3'd3;

    typedef logic [NUM_LINES-1:0] line_vec_t;

    typedef enum logic [2:0] {
        WR_NONE,
        WR_OE_SET,
        WR_OE_CLR,
        WR_DO_SET,
        WR_DO_CLR
    } wr_op_e;

    typedef struct packed {
        wr_op_e    op;
        line_vec_t mask;
    } wr_cmd_t;

    typedef struct packed {
        line_vec_t oe;
        line_vec_t dout;
    } line_state_t;

    function automatic logic [DATA_W-1:0] read_word(
        input logic [WORD_IDX_W-1:0] idx,
        input line_state_t           st,
        input line_vec_t             din
    );
        logic [DATA_W-1:0] w;
        w = '0;
        case (idx)
            IDX_OE_SET: w[NUM_LINES-1:0] = st.oe;
            IDX_DO_SET: w[NUM_LINES-1:0] = st.dout;
            IDX_DO_CLR: w[NUM_LINES-1:0] = din;
            default:    w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/gpio_sc_decode.sv
module gpio_sc_decode
    import gpio_sc_pkg::*;
(
    input  logic                  wr_en,
    input  logic [WORD_IDX_W-1:0] idx,
    input  logic [DATA_W-1:0]     wdata,
    output wr_cmd_t               cmd
);

    always_comb begin
        cmd.mask = wdata[NUM_LINES-1:0];
        cmd.op   = WR_NONE;
        if (wr_en) begin
            case (idx)
                IDX_OE_SET: cmd.op = WR_OE_SET;
                IDX_OE_CLR: cmd.op = WR_OE_CLR;
                IDX_DO_SET: cmd.op = WR_DO_SET;
                IDX_DO_CLR: cmd.op = WR_DO_CLR;
                default:    cmd.op = WR_NONE;
            endcase
        end
    end

endmodule

// File: rtl/gpio_sc_regs.sv
module gpio_sc_regs
    import gpio_sc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  wr_cmd_t     cmd,
    output line_state_t st
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            case (cmd.op)
                WR_OE_SET: st.oe   <= st.oe   |  cmd.mask;
                WR_OE_CLR: st.oe   <= st.oe   & ~cmd.mask;
                WR_DO_SET: st.dout <= st.dout |  cmd.mask;
                WR_DO_CLR: st.dout <= st.dout & ~cmd.mask;
                default:   st      <= st;
            endcase
        end
    end

    // R2: masked bits become 1, others keep their old value
    a_r2_oe_set: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == WR_OE_SET) |=>
            ((st.oe & $past(cmd.mask)) == $past(cmd.mask)) &&
            ((st.oe & ~$past(cmd.mask)) == ($past(st.oe) & ~$past(cmd.mask))) &&
            (st.dout == $past(st.dout)));

    // R3
    a_r3_oe_clr: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == WR_OE_CLR) |=>
            ((st.oe & $past(cmd.mask)) == '0) &&
            ((st.oe & ~$past(cmd.mask)) == ($past(st.oe) & ~$past(cmd.mask))) &&
            (st.dout == $past(st.dout)));

    // R4
    a_r4_do_set: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == WR_DO_SET) |=>
            ((st.dout & $past(cmd.mask)) == $past(cmd.mask)) &&
            ((st.dout & ~$past(cmd.mask)) == ($past(st.dout) & ~$past(cmd.mask))) &&
            (st.oe == $past(st.oe)));

    // R5
    a_r5_do_clr: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == WR_DO_CLR) |=>
            ((st.dout & $past(cmd.mask)) == '0) &&
            ((st.dout & ~$past(cmd.mask)) == ($past(st.dout) & ~$past(cmd.mask))) &&
            (st.oe == $past(st.oe)));

    // R8
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == WR_NONE) |=> $stable(st));

endmodule

// File: rtl/gpio_sc_sync.sv
module gpio_sc_sync
    import gpio_sc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_vec_t raw,
    output line_vec_t synced
);

    line_vec_t stage_q [SYNC_STAGES];

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign synced = stage_q[SYNC_STAGES-1];

    generate
        if (SYNC_STAGES == 2) begin : g_chk
            // R9: two-edge latency from pad to synchronized output
            a_r9_sync_delay: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && !$past(rst, 2)) |-> (synced == $past(raw, 2)));
        end
    endgenerate

endmodule

// File: rtl/gpio_sc_bank.sv
module gpio_sc_bank
    import gpio_sc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr_en,
    input  logic                  bus_rd_en,
    input  logic [WORD_IDX_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [NUM_LINES-1:0]  pad_in,
    output logic [NUM_LINES-1:0]  pad_out,
    output logic [NUM_LINES-1:0]  pad_oe,
    output logic [NUM_LINES-1:0]  in_sync
);

    wr_cmd_t     wr_cmd;
    line_state_t line_st;
    line_vec_t   din_sync;

    gpio_sc_decode u_decode (
        .wr_en (bus_wr_en),
        .idx   (bus_addr),
        .wdata (bus_wdata),
        .cmd   (wr_cmd)
    );

    gpio_sc_regs u_regs (
        .clk (clk),
        .rst (rst),
        .cmd (wr_cmd),
        .st  (line_st)
    );

    gpio_sc_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (pad_in),
        .synced (din_sync)
    );

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_rd_en)
            bus_rdata <= read_word(bus_addr, line_st, din_sync);
    end

    assign pad_out = line_st.dout;
    assign pad_oe  = line_st.oe;
    assign in_sync = din_sync;

    // R1: reset clears the pads and read data
    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (pad_oe == '0 && pad_out == '0 && bus_rdata == '0));

    // R7: the clear-enable and reserved words read as zero
    a_r7_zero_read: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_en && (bus_addr == IDX_OE_CLR || bus_addr[WORD_IDX_W-1])) |=>
            (bus_rdata == '0));

    // R6: the data-word read returns the pad data held before the edge
    a_r6_data_read: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_en && bus_addr == IDX_DO_SET) |=> (bus_rdata == $past(pad_out)));

    // R8: a write to a reserved word leaves the pads unchanged
    a_r8_reserved_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && bus_addr[WORD_IDX_W-1]) |=> ($stable(pad_oe) && $stable(pad_out)));

endmodule

// File: tb/gpio_sc_bank_tb.sv
module gpio_sc_bank_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic [31:0] in_sync;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    gpio_sc_bank u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr_en (bus_wr_en),
        .bus_rd_en (bus_rd_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .in_sync   (in_sync)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // Drive at the falling edge, strobe for one rising edge, return at the falling edge.
    task automatic bus_write(input logic [2:0] idx, input logic [31:0] data);
        bus_addr  = idx;
        bus_wdata = data;
        bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] idx, output logic [31:0] data);
        bus_addr  = idx;
        bus_rd_en = 1'b1;
        @(negedge clk);
        bus_rd_en = 1'b0;
        data = bus_rdata;
    endtask

    task automatic t_reset();
        check("R1 pad_oe", pad_oe, 32'h0);
        check("R1 pad_out", pad_out, 32'h0);
        check("R1 rdata", bus_rdata, 32'h0);
    endtask

    task automatic t_oe();
        logic [31:0] rd;
        bus_write(3'd0, 32'hA5A5_0000);
        check("R2 pad_oe after set", pad_oe, 32'hA5A5_0000);
        bus_write(3'd0, 32'h0000_00FF);
        check("R2 set keeps others", pad_oe, 32'hA5A5_00FF);
        bus_read(3'd0, rd);
        check("R6 read enable word", rd, 32'hA5A5_00FF);
        bus_write(3'd1, 32'hFFFF_000F);
        check("R3 clear enables", pad_oe, 32'h0000_00F0);
        bus_read(3'd0, rd);
        check("R6 read after clear", rd, 32'h0000_00F0);
        bus_read(3'd1, rd);
        check("R7 clear-enable word reads zero", rd, 32'h0);
        check("R3 data untouched", pad_out, 32'h0);
    endtask

    task automatic t_data();
        logic [31:0] rd;
        bus_write(3'd2, 32'h1234_5678);
        check("R4 set data", pad_out, 32'h1234_5678);
        bus_write(3'd3, 32'h0000_0F0F);
        check("R5 clear data", pad_out, 32'h1234_5070);
        bus_read(3'd2, rd);
        check("R6 read data word", rd, 32'h1234_5070);
        check("R5 enables untouched", pad_oe, 32'h0000_00F0);
    endtask

    task automatic t_reserved();
        logic [31:0] rd;
        for (int i = 4; i < 8; i++) begin
            bus_write(3'(i), 32'hFFFF_FFFF);
            check("R8 reserved write oe", pad_oe, 32'h0000_00F0);
            check("R8 reserved write data", pad_out, 32'h1234_5070);
            bus_read(3'(i), rd);
            check("R7 reserved read zero", rd, 32'h0);
        end
    endtask

    task automatic t_sync();
        logic [31:0] rd;
        pad_in = 32'hDEAD_BEEF;
        @(negedge clk);
        check("R9 one edge not yet visible", in_sync, 32'h0);
        @(negedge clk);
        check("R9 visible after two edges", in_sync, 32'hDEAD_BEEF);
        bus_read(3'd3, rd);
        check("R9 input word read", rd, 32'hDEAD_BEEF);
    endtask

    task automatic t_same_cycle();
        logic [31:0] rd;
        bus_addr  = 3'd2;
        bus_wdata = 32'h8000_0001;
        bus_wr_en = 1'b1;
        bus_rd_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
        bus_rd_en = 1'b0;
        check("R10 read sees old value", bus_rdata, 32'h1234_5070);
        bus_read(3'd2, rd);
        check("R10 next read sees new value", rd, 32'h9234_5071);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_oe();
        t_data();
        t_reserved();
        t_sync();
        t_same_cycle();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule